// File: doc/BRIEF.md
# Constant Off-Time Gate Sequencer

This block is the digital timing core of a synchronous step-down converter that runs a current-mode loop with constant off-time. Each conversion cycle starts when the oscillator pulses the cycle-start input. The top-switch enable then rises after one clock of dead time. The top switch stays on until the peak-current comparator trips, and this acts as the reset side of a set/reset latch. An overvoltage input can cut the top switch in the same way.

After the top switch turns off, one more dead-time clock passes and then the bottom switch conducts. It keeps conducting until the reverse-current comparator trips or the next cycle begins, whichever happens first.

An off-time counter decides when the next cycle may begin. It is loaded with a precomputed count at the moment the top switch turns off. While the counter is non-zero, oscillator pulses are ignored. The host computes the count from the input voltage, the battery voltage and the oscillator rate, so that the switching frequency stays nearly constant as the output voltage changes. All comparator inputs are synchronous, active-high digital signals.

Top module: `cot_gate_seq`

## Requirements
- R1: After reset both gate enables are low and the off-time counter is zero, so the first cycle-start pulse is accepted.
- R2: A cycle-start pulse that is accepted, with the peak and overvoltage inputs low, gives one clock with both enables low and then sets top_en_o high. The pulse is sampled at clock edge k, and top_en_o is high after edge k+1.
- R3: While top_en_o is high, a peak-current trip sampled at edge m drops top_en_o after edge m. Both enables stay low for one clock, and bot_en_o rises after edge m+1.
- R4: While bot_en_o is high, a reverse-current trip sampled at an edge drops bot_en_o after that edge, unless a cycle start is accepted at the same edge. Both enables then stay low until a cycle start is accepted. A reverse-current trip has no effect while top_en_o is high.
- R5: A cycle start accepted while bot_en_o is high drops bot_en_o at that edge. top_en_o rises one clock later.
- R6: The off-time counter loads toff_cnt_i at edge m, where the top switch turns off, and counts down once per clock until it reaches zero. A cycle-start pulse sampled before edge m+toff_cnt_i+1 is ignored and leaves the gate enables unchanged. A pulse sampled at that edge or later is accepted.
- R7: While ovp_i is high, top_en_o is low in the following clock. If the top switch is on, ovp_i turns it off through the same dead-time and bottom-on sequence as a peak trip. ovp_i does not affect the bottom switch.
- R8: If ipk_trip_i or ovp_i is high when a cycle start is accepted, that cycle is skipped. top_en_o stays low, bot_en_o is cut, and both enables stay low until the next accepted start.
- R9: top_en_o and bot_en_o are never high together, and every change between them passes through at least one clock with both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Oscillator cycle-start pulse |
| ipk_trip_i | input | 1 | Peak-current comparator trip |
| irev_trip_i | input | 1 | Reverse-current comparator trip |
| ovp_i | input | 1 | Overvoltage comparator active |
| toff_cnt_i | input | CNT_W | Off-time in clocks, loaded when the top switch turns off |
| top_en_o | output | 1 | Top-switch gate enable |
| bot_en_o | output | 1 | Bottom-switch gate enable |

## Verification
On every cycle the assertions check the following:
- the gate exclusion and the dead-time gap;
- that the top switch falls after a peak or overvoltage trip;
- that the bottom switch falls after a reverse-current trip;
- that the counter steps down by one;
- that an oscillator pulse during the blanking window leaves the bottom switch on.

Only the bench scenarios show the exact number of clocks from a start to the rising top switch, and the exact edge at which the off-time window ends. They also show skipped cycles, the zero off-time case, and the top switch ignoring reverse current.

// File: rtl/cot_gate_pkg.sv
package cot_gate_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DT_ON = 3'd1,
    ST_TOP   = 3'd2,
    ST_DT_OF = 3'd3,
    ST_BOT   = 3'd4
  } gate_st_e;
endpackage

// File: rtl/cot_toff_cnt.sv
module cot_toff_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cot_gate_fsm.sv
module cot_gate_fsm
  import cot_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_start_i,
  input  logic ipk_trip_i,
  input  logic irev_trip_i,
  input  logic ovp_i,
  input  logic toff_done_i,
  output logic toff_load_o,
  output logic top_en_o,
  output logic bot_en_o
);
  gate_st_e st_q, st_d;
  logic start_ok, skip;

  assign start_ok = cyc_start_i && toff_done_i;
  assign skip     = ipk_trip_i || ovp_i;

  always_comb begin
    st_d        = st_q;
    toff_load_o = 1'b0;
    unique case (st_q)
      ST_OFF:   if (start_ok) st_d = skip ? ST_OFF : ST_DT_ON;
      ST_DT_ON: st_d = ovp_i ? ST_OFF : ST_TOP;
      ST_TOP: begin
        if (skip) begin
          st_d        = ST_DT_OF;
          toff_load_o = 1'b1;
        end
      end
      ST_DT_OF: st_d = ST_BOT;
      ST_BOT: begin
        if (start_ok)         st_d = skip ? ST_OFF : ST_DT_ON;
        else if (irev_trip_i) st_d = ST_OFF;
      end
      default:  st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign top_en_o = (st_q == ST_TOP);
  assign bot_en_o = (st_q == ST_BOT);

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_en_o && bot_en_o));
  p_gap_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(top_en_o) |-> !$past(bot_en_o));
  p_gap_bot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bot_en_o) |-> !$past(top_en_o));
  p_peak_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_en_o && ipk_trip_i) |=> !top_en_o);
  p_ovp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |=> !top_en_o);
  p_rev_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bot_en_o && irev_trip_i && !start_ok) |=> !bot_en_o);
  p_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bot_en_o && cyc_start_i && !toff_done_i && !irev_trip_i) |=> bot_en_o);
endmodule

// File: rtl/cot_gate_seq.sv
module cot_gate_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_start_i,
  input  logic             ipk_trip_i,
  input  logic             irev_trip_i,
  input  logic             ovp_i,
  input  logic [CNT_W-1:0] toff_cnt_i,
  output logic             top_en_o,
  output logic             bot_en_o
);
  logic toff_load, toff_done;

  cot_toff_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (toff_load),
    .load_val_i (toff_cnt_i),
    .done_o     (toff_done)
  );

  cot_gate_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_start_i (cyc_start_i),
    .ipk_trip_i  (ipk_trip_i),
    .irev_trip_i (irev_trip_i),
    .ovp_i       (ovp_i),
    .toff_done_i (toff_done),
    .toff_load_o (toff_load),
    .top_en_o    (top_en_o),
    .bot_en_o    (bot_en_o)
  );
endmodule

// File: tb/cot_gate_seq_bench.sv
module cot_gate_seq_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_start, ipk, irev, ovp;
  logic [CNT_W-1:0] toff;
  logic top_en, bot_en;

  always #2 clk = ~clk;

  cot_gate_seq #(.CNT_W(CNT_W)) u_cot_gate_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_start_i(cyc_start), .ipk_trip_i(ipk),
    .irev_trip_i(irev), .ovp_i(ovp), .toff_cnt_i(toff),
    .top_en_o(top_en), .bot_en_o(bot_en)
  );

  typedef struct { logic top; logic bot; string tag; } exp_t;
  exp_t sb_q[$];
  int n_cmp = 0, n_bad = 0, wd = 0;
  bit done = 0;

  task automatic chk(input logic t, input logic b, input string tag);
    n_cmp++;
    if (top_en !== t || bot_en !== b) begin
      n_bad++;
      $display("FAIL %s: top/bot=%b%b expected %b%b", tag, top_en, bot_en, t, b);
    end
  endtask

  // apply inputs at negedge, queue expectation for after the next rising edge
  task automatic cyc(input logic s, input logic p, input logic r, input logic o,
                     input logic et, input logic eb, input string tag);
    cyc_start = s; ipk = p; irev = r; ovp = o;
    @(posedge clk);
    sb_q.push_back('{et, eb, tag});
    @(negedge clk);
    cyc_start = 0; ipk = 0; irev = 0; ovp = 0;
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.top, e.bot, e.tag);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 5000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: cycles=%0d expected <=5000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc_start = 0; ipk = 0; irev = 0; ovp = 0; toff = 8'd3;
    repeat (3) @(negedge clk);
    chk(1'b0, 1'b0, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    cyc(1,0,0,0, 0,0, "R1 R2 dead");
    cyc(0,0,0,0, 1,0, "R2 top on");
    cyc(0,0,0,0, 1,0, "R2 top hold");
    cyc(0,1,0,0, 0,0, "R3 dead off");
    cyc(0,0,0,0, 0,1, "R3 bot on");
    cyc(1,0,0,0, 0,1, "R6 blank cnt2");
    cyc(1,0,0,0, 0,1, "R6 blank cnt1");
    cyc(1,0,0,0, 0,0, "R5 R6 accept");
    cyc(0,0,0,0, 1,0, "R5 top on");
    cyc(0,0,0,1, 0,0, "R7 ovp off");
    cyc(0,0,0,1, 0,1, "R7 bot under ovp");
    cyc(0,0,0,0, 0,1, "R4 bot hold");
    cyc(0,0,1,0, 0,0, "R4 irev off");
    cyc(0,0,0,0, 0,0, "R4 stay off");
    cyc(1,1,0,0, 0,0, "R8 skip peak");
    cyc(0,0,0,0, 0,0, "R8 top stays off");
    cyc(1,0,0,1, 0,0, "R8 skip ovp");
    cyc(1,0,0,0, 0,0, "R2 dead");
    cyc(0,0,0,0, 1,0, "R2 top on");
    cyc(0,1,0,0, 0,0, "R3 dead off");
    cyc(0,0,0,0, 0,1, "R3 bot on");
    cyc(0,0,0,0, 0,1, "R6 wait");
    cyc(0,0,0,0, 0,1, "R6 wait");
    cyc(1,1,0,0, 0,0, "R8 skip cuts bot");
    cyc(0,0,0,0, 0,0, "R8 off");
    toff = 8'd0;
    cyc(1,0,0,0, 0,0, "R2 dead");
    cyc(0,0,0,0, 1,0, "R2 top on");
    cyc(0,1,0,0, 0,0, "R3 dead");
    cyc(1,0,0,0, 0,1, "R3 R9 start in dead ignored");
    cyc(1,0,0,0, 0,0, "R6 zero off-time accept");
    cyc(0,0,0,0, 1,0, "R5 top on");
    cyc(0,0,1,0, 1,0, "R4 irev no effect on top");
    cyc(0,1,0,0, 0,0, "R9 gap");
    cyc(0,0,0,0, 0,1, "R9 bot");
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule